// File: doc/BRIEF.md
# Debug Command Decode Controller

This block sits between a JTAG-style test access port and an on-chip debug unit. Each command word arrives already shifted into a data register. It carries a read/write flag, a go flag, an exit flag and a 7-bit register select code. The block decodes the select code into one enable per debug register. When the test access port signals its Update-DR state, the block turns the command into one-cycle write strobes, a resume request or a single-step request.

The block also tracks whether the core is halted or running. Three kinds of request can halt a running core: the debug-request bit of the debug control register, a status-driven request that counts only while external debug mode is on, and an external request. An exit is honoured only when three things hold: go is set, the selection is the CPU scan register or bypass, and the core is halted. A request that is still active after an exit sends the core straight back into the halted state. On every accepted exit, asynchronous interrupts stay masked until the core reports that the first resumed instruction has started.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: The command word `cmd_i` is laid out as follows. Bit 9 is the read flag (1 = read, 0 = write), bit 8 is go and bit 7 is exit. Bits 6:0 hold the register select code. A command acts only in a cycle where `upd_dr_i` is high.
- R2: `sel_en_o` is a continuous one-hot decode of the select code. Code 0000010 (identification, read-only) sets bit 0. Code 0010000 (CPU scan) sets bit 1. Code 0010010 (debug control) sets bit 2.
- R3: Codes 0100000 to 0100011 set bits 3 to 6 (instruction address compares). Codes 0100100 and 0100101 set bits 7 and 8 (data address compares). Code 0100110 sets bit 9 (data value compare). Bypass (0010001) and every reserved code leave `sel_en_o` all zero.
- R4: A write command (bit 9 = 0) to a writable target raises the matching bit of `wr_stb_o` for exactly one cycle. That cycle is the one after the Update-DR cycle. A read command raises no strobe.
- R5: A write to the identification register (bit 0) is discarded: no strobe and no other effect.
- R6: After reset, `halted_o`, `resume_o`, `step_o`, `irq_block_o` and `wr_stb_o` are all 0.
- R7: While the core is running, `halted_o` rises one cycle after any of three requests is seen: `ctl_dbg_req_i`, `ext_req_i`, or `stat_req_i` together with `ext_dbg_mode_i`. `stat_req_i` has no effect while `ext_dbg_mode_i` is 0.
- R8: An exit needs all of these: the core is halted, Update-DR is high, go = 1, exit = 1, and the selection is scan or bypass. The cycle after such an exit, `resume_o` pulses high for one cycle and `halted_o` is 0. Nothing happens before Update-DR.
- R9: An exit flag is ignored in any of these cases: go = 0, another register is selected, or the core is running. The state and `resume_o` are then unchanged.
- R10: If a debug request is active in the cycle after an exit, `halted_o` is 1 again in the following cycle.
- R11: `irq_block_o` is set together with `resume_o`. It clears the cycle after an `instr_start_i` pulse, or when the core halts again.
- R12: A single step needs all of these: the core is halted, Update-DR is high, go = 1, exit = 0, and scan is selected. `step_o` then pulses for one cycle and `halted_o` stays 1. Go without exit on bypass gives no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 10 | Command word from the test data register |
| upd_dr_i | input | 1 | Update-DR strobe from the TAP state machine |
| ctl_dbg_req_i | input | 1 | Debug-request bit of the debug control register |
| stat_req_i | input | 1 | Status-driven debug request |
| ext_dbg_mode_i | input | 1 | External debug mode enable (gates `stat_req_i`) |
| ext_req_i | input | 1 | Other external debug request |
| instr_start_i | input | 1 | Pulse when the core starts executing an instruction |
| sel_en_o | output | 10 | One-hot register select enables |
| wr_stb_o | output | 10 | One-cycle write strobes per register |
| resume_o | output | 1 | Resume request pulse to the core |
| step_o | output | 1 | Execute-single-instruction pulse |
| irq_block_o | output | 1 | Asynchronous interrupt mask |
| halted_o | output | 1 | 1 = core in debug mode, 0 = running |

## Verification
A vector table walks the select code over every named register, over bypass, and over reserved codes placed just below, between and just above the named ranges. This separates an off-by-one range decode from a correct one. Directed commands then vary one field at a time on a halted core: the read flag, go, exit, and a selection of scan, bypass or the control register. This separates an honoured exit from an ignored one, and a single step from a resume. The three request inputs are driven alone, with the external mode gate both on and off, and once held across an exit to show the immediate return to the halted state.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
   localparam int CMD_SEL_W = 7;
   localparam int CMD_W     = CMD_SEL_W + 3;
   localparam int BIT_RD    = CMD_SEL_W + 2;
   localparam int BIT_GO    = CMD_SEL_W + 1;
   localparam int BIT_EX    = CMD_SEL_W;

   localparam int TGT_ID    = 0;
   localparam int TGT_SCAN  = 1;
   localparam int TGT_CTL   = 2;
   localparam int TGT_FIRST_CMP = 3;
endpackage

// File: rtl/dbg_sel_decode.sv
module dbg_sel_decode #(
   parameter int SEL_W   = 7,
   parameter int NUM_IAC = 4,
   parameter int NUM_DAC = 2,
   parameter int NUM_DVC = 1,
   parameter logic [SEL_W-1:0] ID_CODE   = 7'h02,
   parameter logic [SEL_W-1:0] SCAN_CODE = 7'h10,
   parameter logic [SEL_W-1:0] BYP_CODE  = 7'h11,
   parameter logic [SEL_W-1:0] CTL_CODE  = 7'h12,
   parameter logic [SEL_W-1:0] IAC_BASE  = 7'h20,
   localparam int NUM_TGT = dbg_cmd_pkg::TGT_FIRST_CMP + NUM_IAC + NUM_DAC + NUM_DVC
) (
   input  logic [SEL_W-1:0]   sel_i,
   output logic [NUM_TGT-1:0] sel_en_o,
   output logic               is_scan_o,
   output logic               is_byp_o
);
   import dbg_cmd_pkg::*;

   function automatic logic [SEL_W-1:0] tgt_code(input int idx);
      if (idx == TGT_ID)        return ID_CODE;
      else if (idx == TGT_SCAN) return SCAN_CODE;
      else if (idx == TGT_CTL)  return CTL_CODE;
      else                      return IAC_BASE + SEL_W'(idx - TGT_FIRST_CMP);
   endfunction

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
      localparam logic [SEL_W-1:0] CODE = tgt_code(g);
      assign sel_en_o[g] = (sel_i == CODE);
   end

   assign is_scan_o = sel_en_o[TGT_SCAN];
   assign is_byp_o  = (sel_i == BYP_CODE);
endmodule

// File: rtl/dbg_wr_strobe.sv
module dbg_wr_strobe #(
   parameter int NUM_TGT = 10,
   parameter logic [NUM_TGT-1:0] WR_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_i,
   input  logic               rd_i,
   input  logic [NUM_TGT-1:0] sel_en_i,
   output logic [NUM_TGT-1:0] wr_stb_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wr_stb_o <= '0;
      else if (upd_i && !rd_i) wr_stb_o <= sel_en_i & WR_MASK;
      else                   wr_stb_o <= '0;
   end

   // R4: a strobe only ever follows an Update-DR cycle
   assert_stb_after_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_o != '0) |-> $past(upd_i));
   // R4: strobes last one cycle
   assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_o != '0) |=> (wr_stb_o == '0) || $past(upd_i));
   // R5: read-only target never strobed
   assert_no_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_o[dbg_cmd_pkg::TGT_ID]);
endmodule

// File: rtl/dbg_run_state.sv
module dbg_run_state (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_i,
   input  logic go_i,
   input  logic ex_i,
   input  logic is_scan_i,
   input  logic is_byp_i,
   input  logic ctl_req_i,
   input  logic stat_req_i,
   input  logic ext_mode_i,
   input  logic ext_req_i,
   input  logic instr_start_i,
   output logic resume_o,
   output logic step_o,
   output logic irq_block_o,
   output logic halted_o
);
   logic dbg_req;
   logic exit_ok;
   logic step_ok;

   assign dbg_req = ctl_req_i | (stat_req_i & ext_mode_i) | ext_req_i;
   assign exit_ok = halted_o & upd_i & go_i & ex_i & (is_scan_i | is_byp_i);
   assign step_ok = halted_o & upd_i & go_i & !ex_i & is_scan_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_o    <= 1'b0;
         resume_o    <= 1'b0;
         step_o      <= 1'b0;
         irq_block_o <= 1'b0;
      end else begin
         halted_o <= halted_o ? !exit_ok : dbg_req;
         resume_o <= exit_ok;
         step_o   <= step_ok;
         if (exit_ok)
            irq_block_o <= 1'b1;
         else if (instr_start_i || (!halted_o && dbg_req))
            irq_block_o <= 1'b0;
      end
   end

   // R7: a request while running halts the core next cycle
   assert_halt_on_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!halted_o && dbg_req) |=> halted_o);
   // R8: resume only after an Update-DR cycle, and the core is running then
   assert_resume_at_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> ($past(upd_i) && !halted_o && $past(halted_o)));
   // R9: no resume without go
   assert_exit_needs_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> $past(go_i));
   // R11: interrupts masked whenever a resume is issued
   assert_irq_mask_on_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> irq_block_o);
   // R11: instruction start releases the mask
   assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_start_i && !upd_i) |=> !irq_block_o);
   // R12: a single step leaves the core halted
   assert_step_stays_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> (halted_o && !resume_o));
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl #(
   parameter int NUM_IAC = 4,
   parameter int NUM_DAC = 2,
   parameter int NUM_DVC = 1,
   parameter logic [dbg_cmd_pkg::CMD_SEL_W-1:0] ID_CODE   = 7'h02,
   parameter logic [dbg_cmd_pkg::CMD_SEL_W-1:0] SCAN_CODE = 7'h10,
   parameter logic [dbg_cmd_pkg::CMD_SEL_W-1:0] BYP_CODE  = 7'h11,
   parameter logic [dbg_cmd_pkg::CMD_SEL_W-1:0] CTL_CODE  = 7'h12,
   parameter logic [dbg_cmd_pkg::CMD_SEL_W-1:0] IAC_BASE  = 7'h20,
   localparam int NUM_TGT = dbg_cmd_pkg::TGT_FIRST_CMP + NUM_IAC + NUM_DAC + NUM_DVC,
   localparam int CMD_W   = dbg_cmd_pkg::CMD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic               upd_dr_i,
   input  logic               ctl_dbg_req_i,
   input  logic               stat_req_i,
   input  logic               ext_dbg_mode_i,
   input  logic               ext_req_i,
   input  logic               instr_start_i,
   output logic [NUM_TGT-1:0] sel_en_o,
   output logic [NUM_TGT-1:0] wr_stb_o,
   output logic               resume_o,
   output logic               step_o,
   output logic               irq_block_o,
   output logic               halted_o
);
   import dbg_cmd_pkg::*;

   localparam int SEL_W = CMD_SEL_W;
   localparam int LAST_CODE = int'(IAC_BASE) + NUM_TGT - TGT_FIRST_CMP - 1;
   localparam logic [NUM_TGT-1:0] WR_MASK = ~(NUM_TGT'(1) << TGT_ID);

   initial begin
      if (NUM_IAC < 1 || NUM_DAC < 0 || NUM_DVC < 0)
         $fatal(1, "dbg_cmd_ctrl: compare register counts out of range");
      if (LAST_CODE >= (1 << SEL_W))
         $fatal(1, "dbg_cmd_ctrl: compare codes exceed the select field");
      if (IAC_BASE <= CTL_CODE || IAC_BASE <= BYP_CODE)
         $fatal(1, "dbg_cmd_ctrl: compare codes overlap fixed codes");
   end

   logic is_scan;
   logic is_byp;

   dbg_sel_decode #(
      .SEL_W(SEL_W), .NUM_IAC(NUM_IAC), .NUM_DAC(NUM_DAC), .NUM_DVC(NUM_DVC),
      .ID_CODE(ID_CODE), .SCAN_CODE(SCAN_CODE), .BYP_CODE(BYP_CODE),
      .CTL_CODE(CTL_CODE), .IAC_BASE(IAC_BASE)
   ) u_dec (
      .sel_i     (cmd_i[SEL_W-1:0]),
      .sel_en_o  (sel_en_o),
      .is_scan_o (is_scan),
      .is_byp_o  (is_byp)
   );

   dbg_wr_strobe #(.NUM_TGT(NUM_TGT), .WR_MASK(WR_MASK)) u_stb (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (upd_dr_i),
      .rd_i     (cmd_i[BIT_RD]),
      .sel_en_i (sel_en_o),
      .wr_stb_o (wr_stb_o)
   );

   dbg_run_state u_run (
      .clk           (clk),
      .rst_n         (rst_n),
      .upd_i         (upd_dr_i),
      .go_i          (cmd_i[BIT_GO]),
      .ex_i          (cmd_i[BIT_EX]),
      .is_scan_i     (is_scan),
      .is_byp_i      (is_byp),
      .ctl_req_i     (ctl_dbg_req_i),
      .stat_req_i    (stat_req_i),
      .ext_mode_i    (ext_dbg_mode_i),
      .ext_req_i     (ext_req_i),
      .instr_start_i (instr_start_i),
      .resume_o      (resume_o),
      .step_o        (step_o),
      .irq_block_o   (irq_block_o),
      .halted_o      (halted_o)
   );

   // R2: at most one register enabled at a time
   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_en_o));
   // R3: bypass selects no register
   assert_byp_selects_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_byp |-> (sel_en_o == '0));
   // R1: the scan flag matches the scan enable
   assert_scan_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_scan |-> (cmd_i[SEL_W-1:0] == SCAN_CODE));
endmodule

// File: tb/dbg_cmd_ctrl_tb.sv
module dbg_cmd_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] cmd = '0;
   logic       upd = 1'b0;
   logic       ctl_req = 1'b0, stat_req = 1'b0, ext_mode = 1'b0, ext_req = 1'b0;
   logic       istart = 1'b0;
   logic [9:0] sel_en, wr_stb;
   logic       resume, step, irq_blk, halted;
   int         errs = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   dbg_cmd_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .upd_dr_i(upd),
      .ctl_dbg_req_i(ctl_req), .stat_req_i(stat_req), .ext_dbg_mode_i(ext_mode),
      .ext_req_i(ext_req), .instr_start_i(istart),
      .sel_en_o(sel_en), .wr_stb_o(wr_stb), .resume_o(resume), .step_o(step),
      .irq_block_o(irq_blk), .halted_o(halted)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive a command with one Update-DR cycle; returns at the negedge after it
   task automatic update(input logic rd, input logic go, input logic ex, input logic [6:0] sel);
      cmd = {rd, go, ex, sel};
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
   endtask

   // select code, expected one-hot enable (R2, R3)
   localparam int NV = 15;
   localparam logic [16:0] VEC [NV] = '{
      {7'h02, 10'h001}, {7'h10, 10'h002}, {7'h12, 10'h004},
      {7'h20, 10'h008}, {7'h21, 10'h010}, {7'h22, 10'h020}, {7'h23, 10'h040},
      {7'h24, 10'h080}, {7'h25, 10'h100}, {7'h26, 10'h200},
      {7'h11, 10'h000}, {7'h00, 10'h000}, {7'h13, 10'h000},
      {7'h27, 10'h000}, {7'h7F, 10'h000}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      chk("R6 halted", halted, 0);
      chk("R6 resume", resume, 0);
      chk("R6 step", step, 0);
      chk("R6 irq_block", irq_blk, 0);
      chk("R6 wr_stb", wr_stb, 0);

      // R2 / R3 decode table
      for (int i = 0; i < NV; i++) begin
         cmd = {3'b000, VEC[i][16:10]};
         #1;
         chk("R2_R3 sel_en", sel_en, VEC[i][9:0]);
         @(negedge clk);
      end

      // R4 write strobe, one cycle, on IAC2 (code 0100001, bit 4)
      update(1'b0, 1'b0, 1'b0, 7'h21);
      chk("R4 write strobe", wr_stb, 10'h010);
      @(negedge clk);
      chk("R4 strobe one cycle", wr_stb, 0);
      // R4 read gives no strobe (R1 bit 9 = read)
      update(1'b1, 1'b0, 1'b0, 7'h21);
      chk("R4 R1 read no strobe", wr_stb, 0);
      // R5 write to read-only identification register
      update(1'b0, 1'b0, 1'b0, 7'h02);
      chk("R5 ro write strobe", wr_stb, 0);
      chk("R5 ro write halted", halted, 0);

      // R7 status request gated by external mode
      stat_req = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 status without mode", halted, 0);
      ext_mode = 1'b1;
      @(negedge clk);
      chk("R7 status with mode", halted, 1);
      stat_req = 1'b0; ext_mode = 1'b0;
      @(negedge clk);

      // R9 exit without go, and go+exit on control register
      update(1'b1, 1'b0, 1'b1, 7'h10);
      chk("R9 no go resume", resume, 0);
      chk("R9 no go halted", halted, 1);
      update(1'b0, 1'b1, 1'b1, 7'h12);
      chk("R9 ctl sel resume", resume, 0);
      chk("R9 ctl sel halted", halted, 1);

      // R12 single step on scan
      update(1'b1, 1'b1, 1'b0, 7'h10);
      chk("R12 step pulse", step, 1);
      chk("R12 still halted", halted, 1);
      @(negedge clk);
      chk("R12 step one cycle", step, 0);
      update(1'b1, 1'b1, 1'b0, 7'h11);
      chk("R12 bypass no step", step, 0);

      // R8 nothing before Update-DR, then exit on scan
      cmd = {1'b1, 1'b1, 1'b1, 7'h10};
      repeat (2) @(negedge clk);
      chk("R8 no resume before update", resume, 0);
      chk("R8 halted before update", halted, 1);
      update(1'b1, 1'b1, 1'b1, 7'h10);
      chk("R8 resume pulse", resume, 1);
      chk("R8 running", halted, 0);
      chk("R11 mask set", irq_blk, 1);
      @(negedge clk);
      chk("R8 resume one cycle", resume, 0);
      chk("R11 mask held", irq_blk, 1);
      istart = 1'b1;
      @(negedge clk);
      istart = 1'b0;
      chk("R11 mask released", irq_blk, 0);

      // R9 exit while running is ignored
      update(1'b0, 1'b1, 1'b1, 7'h11);
      chk("R9 running resume", resume, 0);
      chk("R9 running halted", halted, 0);

      // R7 external request halts
      ext_req = 1'b1;
      @(negedge clk);
      ext_req = 1'b0;
      chk("R7 ext request", halted, 1);

      // R10 exit via bypass with control request still set
      ctl_req = 1'b1;
      update(1'b0, 1'b1, 1'b1, 7'h11);
      chk("R8 bypass resume", resume, 1);
      chk("R8 bypass running", halted, 0);
      @(negedge clk);
      chk("R10 re-entry", halted, 1);
      chk("R11 mask cleared on halt", irq_blk, 0);
      ctl_req = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule